// File: doc/BRIEF.md
# Atomic Read-Modify-Write Word Memory

This block holds a 64-word by 32-bit memory and serves one stream of requests against it. Besides plain loads and stores it runs two synchronisation primitives. Test-and-set serves as a spin lock. Compare-and-swap serves as a non-blocking update. In both, the write depends on the word that was just read.

Each request carries a 2-bit opcode, a word address and two operands. Operand A is the store data or the expected value. Operand B is the replacement value. A response gives back the word that was at the address before the request, plus a flag that is set only for a compare-and-swap that matched.

Loads and stores finish in one step. An atomic request takes two steps. The read happens in the accepting cycle, in state `ST_IDLE`. The conditional write happens in the following cycle, in state `ST_COMMIT`. The request-ready output is low during that second cycle, so no other access can reach the word between the read and the write.

The controller has two transitions. `ST_IDLE -> ST_COMMIT` is taken when an atomic request is accepted. `ST_COMMIT -> ST_IDLE` is always taken after one cycle. Software releases a lock by storing zero to the lock word.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset every memory word reads as zero, the response-valid output is low and request-ready is high.
- R2: A load (opcode 00) accepted at a clock edge gives a response-valid pulse after that edge. The response carries the addressed word, with the status flag low.
- R3: A store (opcode 01) writes operand A to the addressed word. Its response comes after the accepting edge and returns the word held before the store, with the status flag low. Storing zero to a lock word releases it.
- R4: A test-and-set (opcode 10) on a word that holds zero returns zero and leaves the word at 1. The status flag is low.
- R5: A test-and-set on a nonzero word returns that word and leaves memory unchanged. The status flag is low.
- R6: A compare-and-swap (opcode 11) whose operand A equals the stored word writes operand B to the word. It returns the old word, which equals operand A, and raises the status flag.
- R7: A compare-and-swap whose operand A differs from the stored word leaves memory unchanged. It returns the stored word with the status flag low.
- R8: After an atomic request is accepted, request-ready is low for exactly one cycle. The response is valid after the second edge. A request waiting during that cycle is accepted only afterwards, so it sees the atomic's write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_op | input | 2 | 00 load, 01 store, 10 test-and-set, 11 compare-and-swap |
| req_addr | input | 6 | Word address |
| req_a | input | 32 | Store data or expected value |
| req_b | input | 32 | Replacement value for compare-and-swap |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_data | output | 32 | Word held at the address before the request |
| rsp_ok | output | 1 | Compare-and-swap succeeded |

## Verification
A load or store is accepted at edge k, and its response is valid between edges k and k+1. An atomic request accepted at edge k holds request-ready low between edges k and k+1, and its response is valid between edges k+1 and k+2. The bench changes inputs and samples outputs only on falling edges. For atomic requests it samples an extra falling edge, at which it checks that request-ready is low and no response has appeared yet. Expected words come from a shadow array in the bench that the bench updates by the rules above. A separate sequence holds a load pending during the commit cycle and checks that the load sees the value the atomic wrote.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_TAS   = 2'b10,
        OP_CAS   = 2'b11
    } rmw_op_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_COMMIT = 1'b1
    } rmw_state_e;

endpackage

// File: rtl/rmw_word_store.sv
module rmw_word_store #(
    parameter  int DEPTH = 64,
    parameter  int WIDTH = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data
);

    logic [WIDTH-1:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cells[g] <= '0;
            end else if (wr_en && (wr_addr == AW'(g))) begin
                cells[g] <= wr_data;
            end
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/rmw_decide.sv
module rmw_decide
    import rmw_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  rmw_op_e          op,
    input  logic [WIDTH-1:0] old_word,
    input  logic [WIDTH-1:0] cmp_word,
    input  logic [WIDTH-1:0] swap_word,
    output logic             wr_en,
    output logic [WIDTH-1:0] wr_data,
    output logic             swap_ok
);

    always_comb begin
        wr_en   = 1'b0;
        wr_data = old_word;
        swap_ok = 1'b0;
        unique case (op)
            OP_TAS: begin
                wr_en   = (old_word == '0);
                wr_data = WIDTH'(1);
            end
            OP_CAS: begin
                wr_en   = (old_word == cmp_word);
                wr_data = swap_word;
                swap_ok = (old_word == cmp_word);
            end
            default: begin
                wr_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
    import rmw_pkg::*;
#(
    parameter int AW    = 6,
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  rmw_op_e          req_op,
    input  logic [AW-1:0]    req_addr,
    input  logic [WIDTH-1:0] req_a,
    input  logic [WIDTH-1:0] req_b,
    output logic [AW-1:0]    mem_rd_addr,
    input  logic [WIDTH-1:0] mem_rd_data,
    output logic             mem_wr_en,
    output logic [AW-1:0]    mem_wr_addr,
    output logic [WIDTH-1:0] mem_wr_data,
    output rmw_op_e          dec_op,
    output logic [WIDTH-1:0] dec_old,
    output logic [WIDTH-1:0] dec_cmp,
    output logic [WIDTH-1:0] dec_swap,
    input  logic             dec_wr_en,
    input  logic [WIDTH-1:0] dec_wr_data,
    input  logic             dec_ok,
    output logic             rsp_valid,
    output logic [WIDTH-1:0] rsp_data,
    output logic             rsp_ok
);

    rmw_state_e       state_q, state_d;
    rmw_op_e          op_q;
    logic [AW-1:0]    addr_q;
    logic [WIDTH-1:0] cmp_q, swap_q, old_q;
    logic             take, take_atomic;

    assign req_ready   = (state_q == ST_IDLE);
    assign take        = req_valid && req_ready;
    assign take_atomic = take && (req_op == OP_TAS || req_op == OP_CAS);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (take_atomic) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // memory-side outputs
    always_comb begin
        mem_rd_addr = req_addr;
        mem_wr_en   = 1'b0;
        mem_wr_addr = req_addr;
        mem_wr_data = req_a;
        unique case (state_q)
            ST_IDLE: begin
                mem_wr_en = take && (req_op == OP_STORE);
            end
            ST_COMMIT: begin
                mem_wr_en   = dec_wr_en;
                mem_wr_addr = addr_q;
                mem_wr_data = dec_wr_data;
            end
            default: mem_wr_en = 1'b0;
        endcase
    end

    assign dec_op   = op_q;
    assign dec_old  = old_q;
    assign dec_cmp  = cmp_q;
    assign dec_swap = swap_q;

    // operand capture for the commit step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_LOAD;
            addr_q <= '0;
            cmp_q  <= '0;
            swap_q <= '0;
            old_q  <= '0;
        end else if (take_atomic) begin
            op_q   <= req_op;
            addr_q <= req_addr;
            cmp_q  <= req_a;
            swap_q <= req_b;
            old_q  <= mem_rd_data;
        end
    end

    // response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_ok    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    rsp_valid <= take && !take_atomic;
                    rsp_data  <= mem_rd_data;
                    rsp_ok    <= 1'b0;
                end
                ST_COMMIT: begin
                    rsp_valid <= 1'b1;
                    rsp_data  <= old_q;
                    rsp_ok    <= dec_ok;
                end
                default: begin
                    rsp_valid <= 1'b0;
                    rsp_ok    <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
    import rmw_pkg::*;
#(
    parameter  int DEPTH = 64,
    parameter  int WIDTH = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic [AW-1:0]    req_addr,
    input  logic [WIDTH-1:0] req_a,
    input  logic [WIDTH-1:0] req_b,
    output logic             rsp_valid,
    output logic [WIDTH-1:0] rsp_data,
    output logic             rsp_ok
);

    logic [AW-1:0]    rd_addr, wr_addr;
    logic [WIDTH-1:0] rd_data, wr_data;
    logic             wr_en;
    rmw_op_e          d_op;
    logic [WIDTH-1:0] d_old, d_cmp, d_swap, d_wdata;
    logic             d_wen, d_ok;

    rmw_ctrl #(.AW(AW), .WIDTH(WIDTH)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_op      (rmw_op_e'(req_op)),
        .req_addr    (req_addr),
        .req_a       (req_a),
        .req_b       (req_b),
        .mem_rd_addr (rd_addr),
        .mem_rd_data (rd_data),
        .mem_wr_en   (wr_en),
        .mem_wr_addr (wr_addr),
        .mem_wr_data (wr_data),
        .dec_op      (d_op),
        .dec_old     (d_old),
        .dec_cmp     (d_cmp),
        .dec_swap    (d_swap),
        .dec_wr_en   (d_wen),
        .dec_wr_data (d_wdata),
        .dec_ok      (d_ok),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .rsp_ok      (rsp_ok)
    );

    rmw_decide #(.WIDTH(WIDTH)) u_decide (
        .op        (d_op),
        .old_word  (d_old),
        .cmp_word  (d_cmp),
        .swap_word (d_swap),
        .wr_en     (d_wen),
        .wr_data   (d_wdata),
        .swap_ok   (d_ok)
    );

    rmw_word_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

endmodule

// File: rtl/atomic_rmw_unit_chk.sv
module atomic_rmw_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [1:0] req_op,
    input logic       rsp_valid,
    input logic       rsp_ok
);

    logic take;
    assign take = req_valid && req_ready;

    assert_atomic_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_op[1]) |=> !req_ready);

    assert_block_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> req_ready);

    assert_atomic_rsp_timing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_op[1]) |=> (!rsp_valid ##1 rsp_valid));

    assert_plain_rsp_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !req_op[1]) |=> rsp_valid);

    assert_load_flag_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_op == 2'b00) |=> !rsp_ok);

    assert_tas_flag_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_op == 2'b10) |=> ##1 !rsp_ok);

    assert_flag_with_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ok |-> rsp_valid);

endmodule

bind atomic_rmw_unit atomic_rmw_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .rsp_valid (rsp_valid),
    .rsp_ok    (rsp_ok)
);

// File: tb/atomic_rmw_unit_tb.sv
module atomic_rmw_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'b00;
    logic [5:0]  req_addr = '0;
    logic [31:0] req_a = '0;
    logic [31:0] req_b = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        rsp_ok;

    int checks = 0;
    int fails  = 0;
    logic [31:0] mdl [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    atomic_rmw_unit u_dut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
        .req_op (req_op), .req_addr (req_addr), .req_a (req_a), .req_b (req_b),
        .rsp_valid (rsp_valid), .rsp_data (rsp_data), .rsp_ok (rsp_ok)
    );

    task automatic check(input bit cond, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic txn(input logic [1:0] op, input int addr, input logic [31:0] a,
                       input logic [31:0] b, output logic [31:0] d, output logic k);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = 6'(addr); req_a = a; req_b = b;
        @(negedge clk);
        req_valid = 1'b0;
        if (op[1]) begin
            check(req_ready == 1'b0, "R8 ready low in commit", 32'(req_ready), 32'd0);
            check(rsp_valid == 1'b0, "R8 no early response", 32'(rsp_valid), 32'd0);
            @(negedge clk);
        end
        check(rsp_valid == 1'b1, op[1] ? "R8 atomic response" : "R2 response timing",
              32'(rsp_valid), 32'd1);
        d = rsp_data;
        k = rsp_ok;
    endtask

    function automatic logic [31:0] pat(input int i);
        return (i % 2 == 1) ? 32'(i) * 32'h9E3779B1 : 32'd0;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic        k;
        logic [31:0] e;
        for (int i = 0; i < N; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
        check(rsp_valid == 1'b0, "R1 no response after reset", 32'(rsp_valid), 32'd0);

        for (int i = 0; i < N; i++) begin
            txn(2'b00, i, '0, '0, d, k);
            check(d == 32'd0, "R1 word zero after reset", d, 32'd0);
            check(k == 1'b0, "R2 load flag", 32'(k), 32'd0);
        end

        for (int i = 0; i < N; i++) begin
            txn(2'b01, i, pat(i), '0, d, k);
            check(d == mdl[i] && k == 1'b0, "R3 store returns old word", d, mdl[i]);
            mdl[i] = pat(i);
        end
        for (int i = 0; i < N; i++) begin
            txn(2'b00, i, '0, '0, d, k);
            check(d == mdl[i], "R2 load after store", d, mdl[i]);
        end

        for (int i = 0; i < N; i++) begin
            txn(2'b10, i, '0, '0, d, k);
            if (mdl[i] == 0) begin
                check(d == 32'd0 && k == 1'b0, "R4 tas acquires", d, 32'd0);
                mdl[i] = 32'd1;
            end else begin
                check(d == mdl[i] && k == 1'b0, "R5 tas busy", d, mdl[i]);
            end
        end
        for (int i = 0; i < N; i++) begin
            txn(2'b00, i, '0, '0, d, k);
            check(d == mdl[i], (i % 2 == 0) ? "R4 lock word set" : "R5 word unchanged", d, mdl[i]);
        end

        for (int i = 0; i < N; i += 2) begin
            txn(2'b01, i, 32'd0, '0, d, k);
            check(d == 32'd1, "R3 release returns held lock", d, 32'd1);
            mdl[i] = 32'd0;
            txn(2'b10, i, '0, '0, d, k);
            check(d == 32'd0, "R4 reacquire after release", d, 32'd0);
            mdl[i] = 32'd1;
        end

        for (int i = 0; i < N; i++) begin
            e = (i % 3 == 0) ? (mdl[i] ^ 32'h1) : mdl[i];
            txn(2'b11, i, e, 32'hC0DE0000 ^ 32'(i), d, k);
            if (e == mdl[i]) begin
                check(d == e && k == 1'b1, "R6 cas match", d, e);
                mdl[i] = 32'hC0DE0000 ^ 32'(i);
            end else begin
                check(d == mdl[i] && k == 1'b0, "R7 cas mismatch", d, mdl[i]);
            end
        end
        for (int i = 0; i < N; i++) begin
            txn(2'b00, i, '0, '0, d, k);
            check(d == mdl[i], (i % 3 == 0) ? "R7 memory unchanged" : "R6 new value stored", d, mdl[i]);
        end

        // R8: a load waiting during the commit cycle must see the atomic's write
        txn(2'b01, 5, 32'd0, '0, d, k);
        mdl[5] = 32'd0;
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'b10; req_addr = 6'd5;
        @(negedge clk);
        check(req_ready == 1'b0, "R8 ready low in commit", 32'(req_ready), 32'd0);
        req_op = 2'b00;
        @(negedge clk);
        check(rsp_valid == 1'b1 && rsp_data == 32'd0, "R8 tas result", rsp_data, 32'd0);
        check(req_ready == 1'b1, "R8 ready back", 32'(req_ready), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid == 1'b1 && rsp_data == 32'd1, "R8 waiting load sees write", rsp_data, 32'd1);

        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule